// File: doc/BRIEF.md
# Neighbour-Comparison Response Analyzer Array with Serial OR Chain

This block sits beside a row of identically configured blocks under test. Each analyzer looks at the outputs of two adjacent blocks in the row. While they agree, the analyzer keeps a stored pass bit at 1. The first time they differ during an enabled compare cycle, the bit drops to 0 and stays there until the next test begins. A group of `NUM_CMP` analyzers watches `NUM_CMP+1` blocks, and each block output is `OUT_W` bits wide. Analyzer `i` sees block `i` and block `i+1`.

The stored bits are joined into a combinational chain of carry-style multiplexers. The first stage takes the test-data-in pin. The last stage drives the test-data-out pin. A passing stage passes its carry-in along, and a failing stage forces a constant 1 into the chain. As a result, one output bit gives the pass/fail result for the whole row. At the end of a test, toggling the input pin checks that the chain itself is intact.

When that bit shows a failure, a parallel vector with one bit per analyzer shows which neighbour pairs disagreed. This lets the faulty block be located.

Top module: `ora_array`

## Requirements
- R1: After reset (active-low `rst_n`), every analyzer holds a pass, so `fail_vec` is all zeros.
- R2: If `compare_en` is 1 and the two slices seen by analyzer `i` differ in any bit at a rising clock edge, `fail_vec[i]` is 1 after that edge.
- R3: A failed analyzer stays failed on later edges, even when its inputs agree again, until reset or `clear`.
- R4: While `compare_en` is 0, mismatches on the block outputs leave every analyzer state unchanged.
- R5: A synchronous `clear` returns every analyzer to pass on the next edge. It takes priority over a mismatch in the same cycle.
- R6: While at least one analyzer has failed, `tdo` is 1 for both values of `tdi`.
- R7: While no analyzer has failed, `tdo` equals `tdi` in the same cycle, with no register in the path.
- R8: Analyzer `i` compares bits `[i*OUT_W +: OUT_W]` with bits `[(i+1)*OUT_W +: OUT_W]` of `but_out`. A fault on an inner block therefore flags both analyzers that share it, and a fault on an end block flags only one.
- R9: `fail_vec[i]` reports analyzer `i`, where 1 means failed and 0 means passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; sets all analyzers to pass |
| clear | input | 1 | Synchronous start-of-test clear; sets all analyzers to pass |
| compare_en | input | 1 | Marks cycles whose block outputs are valid for comparison |
| but_out | input | (NUM_CMP+1)*OUT_W | Concatenated outputs of the blocks under test; block `k` occupies bits `[k*OUT_W +: OUT_W]` |
| tdi | input | 1 | Chain input feeding the first stage |
| tdo | output | 1 | Chain output; 1 on any failure, otherwise equal to `tdi` |
| fail_vec | output | NUM_CMP | Per-analyzer failure flags, 1 = failed |

## Verification
Several behaviours are checked by properties on every cycle: the latch on an enabled mismatch, stickiness, clear priority, disabled compare cycles leaving state alone, and the two chain rules that relate `tdo` to `tdi` and the failure flags. Other behaviours can only be shown by the bench's scenarios. These are the neighbour mapping (which analyzers a fault on a given block and bit must flag), the exact per-analyzer position in `fail_vec`, and the chain output for both `tdi` values after each injected fault. To cover them, the bench sweeps every block and every bit of a small configuration and also injects faults on two blocks at once.

// File: rtl/ora_pkg.sv
package ora_pkg;

  // One stage of the result chain: a passing stage forwards its carry-in,
  // a failing stage injects a constant 1.
  function automatic logic chain_step(input logic stage_pass, input logic carry_in);
    return stage_pass ? carry_in : 1'b1;
  endfunction

  // Next value of a stored pass bit.
  function automatic logic pass_next(input logic cur_pass, input logic do_clear,
                                     input logic hit);
    if (do_clear) return 1'b1;
    if (hit)      return 1'b0;
    return cur_pass;
  endfunction

endpackage

// File: rtl/ora_cell.sv
module ora_cell #(
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             compare_en,
  input  logic [OUT_W-1:0] lhs,
  input  logic [OUT_W-1:0] rhs,
  output logic             pass_q
);
  import ora_pkg::*;

  function automatic logic slices_differ(input logic [OUT_W-1:0] a,
                                         input logic [OUT_W-1:0] b);
    return |(a ^ b);
  endfunction

  logic mismatch;
  logic hit;

  assign mismatch = slices_differ(lhs, rhs);
  assign hit      = compare_en & mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pass_q <= 1'b1;
    else        pass_q <= pass_next(pass_q, clear, hit);
  end

  AST_MISMATCH_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (compare_en && mismatch && !clear) |=> !pass_q); // R2

  AST_FAIL_IS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_q && !clear) |=> !pass_q); // R3

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!compare_en && !clear) |=> $stable(pass_q)); // R4

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> pass_q); // R5

endmodule

// File: rtl/ora_link.sv
module ora_link (
  input  logic stage_pass,
  input  logic carry_in,
  output logic carry_out
);
  import ora_pkg::*;

  assign carry_out = chain_step(stage_pass, carry_in);

endmodule

// File: rtl/ora_array.sv
module ora_array #(
  parameter int NUM_CMP = 6,
  parameter int OUT_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         compare_en,
  input  logic [(NUM_CMP+1)*OUT_W-1:0] but_out,
  input  logic                         tdi,
  output logic                         tdo,
  output logic [NUM_CMP-1:0]           fail_vec
);
  localparam int NUM_BLK = NUM_CMP + 1;

  logic [NUM_CMP-1:0] pass_bits;
  logic [NUM_CMP:0]   carry;
  logic               any_fail;

  assign carry[0] = tdi;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_stage
    ora_cell #(.OUT_W(OUT_W)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .compare_en (compare_en),
      .lhs        (but_out[i*OUT_W +: OUT_W]),
      .rhs        (but_out[(i+1)*OUT_W +: OUT_W]),
      .pass_q     (pass_bits[i])
    );

    ora_link u_link (
      .stage_pass (pass_bits[i]),
      .carry_in   (carry[i]),
      .carry_out  (carry[i+1])
    );
  end

  assign tdo      = carry[NUM_CMP];
  assign fail_vec = ~pass_bits;
  assign any_fail = |fail_vec;

  AST_FAIL_FORCES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    any_fail |-> tdo); // R6

  AST_PASS_FOLLOWS_TDI: assert property (@(posedge clk) disable iff (!rst_n)
    !any_fail |-> (tdo == tdi)); // R7

  AST_RESET_ALL_PASS: assert property (@(posedge clk)
    $rose(rst_n) |-> (fail_vec == '0)); // R1

  initial begin
    assert (NUM_BLK >= 2) else $error("ora_array needs at least one analyzer");
  end

endmodule

// File: tb/sim_ora_array.sv
module sim_ora_array;
  localparam int N  = 4;
  localparam int W  = 3;
  localparam int BW = (N + 1) * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          compare_en = 1'b0;
  logic [BW-1:0] but_out = '0;
  logic          tdi = 1'b0;
  logic          tdo;
  logic [N-1:0]  fail_vec;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ora_array #(.NUM_CMP(N), .OUT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .compare_en(compare_en),
    .but_out(but_out), .tdi(tdi), .tdo(tdo), .fail_vec(fail_vec)
  );

  // All blocks show pat; if fk >= 0, bit fb of block fk is inverted.
  function automatic logic [BW-1:0] make_vec(input logic [W-1:0] pat,
                                             input int fk, input int fb);
    logic [BW-1:0] v;
    for (int k = 0; k <= N; k++) v[k*W +: W] = pat;
    if (fk >= 0) v[fk*W + fb] = ~v[fk*W + fb];
    return v;
  endfunction

  // Analyzers that must flag a fault on block fk: the ones on either side of it.
  function automatic logic [N-1:0] expect_flags(input int fk);
    logic [N-1:0] e = '0;
    if (fk > 0) e[fk-1] = 1'b1;
    if (fk < N) e[fk]   = 1'b1;
    return e;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic check_chain(input string tag, input logic [N-1:0] flags);
    for (int t = 0; t < 2; t++) begin
      tdi = t[0];
      #1;
      check(tag, {{(N-1){1'b0}}, tdo}, {{(N-1){1'b0}}, ((flags != '0) ? 1'b1 : t[0])});
    end
  endtask

  task automatic do_clear(input logic [W-1:0] pat);
    @(negedge clk);
    clear = 1'b1; compare_en = 1'b0; but_out = make_vec(pat, -1, 0);
    @(negedge clk);
    clear = 1'b0;
  endtask

  initial begin
    logic [W-1:0] pat;
    repeat (3) @(negedge clk);
    check("R1 reset flags", fail_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flags after reset release", fail_vec, '0);
    check_chain("R7 chain follows tdi after reset", '0);

    // Sweep every block and every bit.
    for (int k = 0; k <= N; k++) begin
      for (int b = 0; b < W; b++) begin
        pat = W'(k * 5 + b * 3);
        do_clear(pat);
        check("R5 clear leaves all passing", fail_vec, '0);
        compare_en = 1'b1;
        but_out = make_vec(pat, k, b);
        @(negedge clk);
        but_out = make_vec(pat, -1, 0);
        check("R2 R8 R9 fault flags", fail_vec, expect_flags(k));
        check_chain("R6 chain forced by fault", expect_flags(k));
        @(negedge clk);
        check("R3 flags sticky after agreement", fail_vec, expect_flags(k));
      end
    end

    // Disabled compare cycles are ignored.
    do_clear(3'b101);
    compare_en = 1'b0;
    for (int c = 0; c < 3; c++) begin
      but_out = make_vec(3'b101, c, c % W);
      @(negedge clk);
    end
    check("R4 disabled cycles ignored", fail_vec, '0);
    check_chain("R7 chain transparent when passing", '0);

    // Clear beats a simultaneous mismatch.
    compare_en = 1'b1;
    but_out = make_vec(3'b010, 2, 1);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    but_out = make_vec(3'b010, -1, 0);
    check("R5 clear priority over mismatch", fail_vec, '0);

    // Two faulty end blocks at once.
    but_out = make_vec(3'b110, 0, 2);
    but_out[N*W] = ~but_out[N*W];
    @(negedge clk);
    but_out = make_vec(3'b110, -1, 0);
    check("R8 R9 both end blocks", fail_vec, expect_flags(0) | expect_flags(N));
    check_chain("R6 chain with two failures", 4'b1001);

    // Clear after failures restores pass.
    do_clear(3'b110);
    check("R5 clear after failures", fail_vec, '0);
    check_chain("R7 chain after clear", '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule